// File: doc/BRIEF.md
# UART Interrupt Source Combiner

This block gathers the four interrupt causes of a serial port (receive, line error, transmit and modem) into one active-high level interrupt line. Each cause arrives as a one-cycle set pulse and is held in a sticky source register. A mask register suppresses causes, and a pending register holds the unmasked causes. Software reads all three through a small register port and acknowledges interrupts by writing ones.

The transmit cause can also be raised again by the block itself. While the FIFOs are on, the transmit cause is set in every cycle in which the transmit fill count is at or below a threshold. The threshold is the 3-bit trigger field multiplied by a factor that depends on the static port number. Because of this, a software clear does not hold while the transmit FIFO stays below its threshold.

Top module: `uart_irq_combiner`

## Requirements
- R1: A set pulse latches its cause into the source register on the next clock edge: receive in bit 0, error in bit 1, transmit in bit 2, modem in bit 3.
- R2: The pending register (byte offset 0x30) always equals the source register (0x34) AND NOT the mask register (0x38). Writing the mask register stores bits 3:0, and a 1 in a mask bit blocks that cause.
- R3: `irq` is high in exactly those cycles in which the pending register is nonzero.
- R4: Writing to offset 0x30 clears every bit written as 1 in both the pending register and the source register.
- R5: Writing to offset 0x34 clears every source bit written as 1. The pending register follows.
- R6: While `fifo_on` is 1, the transmit source bit is set in every cycle in which `tx_fill` is less than or equal to the threshold. While `fifo_on` is 0 this never happens.
- R7: The threshold is `tx_trig`×32 for port 0, ×8 for ports 1 and 4, ×2 for ports 2 and 3, and 0 for any other port number.
- R8: When a set (a pulse, or the transmit threshold) and a clear write hit the same bit in one cycle, the bit ends up set.
- R9: After reset all three registers read zero. Bits 31:4 of every register read zero. Reads of other offsets return zero.
- R10: A write to any offset other than 0x30, 0x34 or 0x38 changes no register, and `irq` is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 6 | Byte offset of the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 6 | Byte offset of the read |
| reg_rd_data | output | 32 | Read data, combinational from the registers |
| rx_set | input | 1 | Receive cause pulse |
| err_set | input | 1 | Error cause pulse |
| tx_set | input | 1 | Transmit cause pulse (a byte was queued) |
| modem_set | input | 1 | Modem cause pulse |
| fifo_on | input | 1 | FIFO mode enabled |
| tx_fill | input | 8 | Current transmit FIFO entry count |
| tx_trig | input | 3 | Transmit trigger field |
| chan_id | input | 3 | Static serial port number |
| irq | output | 1 | Level interrupt request |

## Verification
The bench aims at the exact threshold edge for every port-number class, including an unused port number. A wrong factor or a strict comparison would show up as a missing or extra transmit bit one fill value from the edge. It collides a clear write with a set pulse, and with an active transmit threshold, on the same bit. A design that lets the clear win would drop a cause that the hardware has just raised. It also acknowledges through the pending offset while the cause is masked, which shows whether the source bit is cleared along with the pending bit. Finally, it writes to an unmapped offset and writes ones into the upper mask bits, and checks that no register changes and that the upper bits read as zero.

// File: rtl/uirq_pkg.sv
// Package: shared constants for the UART interrupt combiner.
// Holds the cause bit positions, the register byte offsets and the
// per-port threshold scale function.
package uirq_pkg;
    localparam int SRC_N    = 4;
    localparam int BIT_RX   = 0;
    localparam int BIT_ERR  = 1;
    localparam int BIT_TX   = 2;
    localparam int BIT_MDM  = 3;

    localparam int OFF_PEND = 'h30;
    localparam int OFF_SRC  = 'h34;
    localparam int OFF_MASK = 'h38;

    // Largest scale factor is 32, i.e. a left shift of 5 bits.
    localparam int SCALE_BITS = 5;

    // Multiplier that turns the trigger field into a fill threshold.
    function automatic int unsigned chan_scale(input int unsigned ch);
        case (ch)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/uirq_tx_level.sv
// Module: uirq_tx_level
// Computes the transmit fill threshold from the trigger field and the
// port number. It flags when the transmit cause has to be raised again.
// Assumes chan_id is static during operation; the logic is purely combinational.
module uirq_tx_level #(
    parameter int TRIG_W = 3,
    parameter int CHAN_W = 3,
    parameter int CNT_W  = 8,
    parameter int LVL_W  = TRIG_W + uirq_pkg::SCALE_BITS
) (
    input  logic [TRIG_W-1:0] tx_trig,
    input  logic [CHAN_W-1:0] chan_id,
    input  logic [CNT_W-1:0]  tx_fill,
    input  logic              fifo_on,
    output logic [LVL_W-1:0]  level,
    output logic              tx_regen
);
    localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

    // Scale the trigger field by the port-dependent factor.
    always_comb begin
        level = LVL_W'(int'(tx_trig) * int'(uirq_pkg::chan_scale(int'(chan_id))));
    end

    // Raise the transmit cause while FIFO mode is on and the fill count is at or below the threshold.
    always_comb begin
        tx_regen = fifo_on && (CMP_W'(tx_fill) <= CMP_W'(level));
    end
endmodule

// File: rtl/uirq_src_bank.sv
// Module: uirq_src_bank
// Holds the sticky source register, the mask and the pending register.
// Sets take priority over clears on the same bit. The pending register and
// irq are registered from the next-state values, so they move in the same
// cycle as the source bits.
module uirq_src_bank #(
    parameter int SRC_N = uirq_pkg::SRC_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] set_vec,
    input  logic [SRC_N-1:0] clr_vec,
    input  logic             mask_we,
    input  logic [SRC_N-1:0] mask_wd,
    output logic [SRC_N-1:0] src_q,
    output logic [SRC_N-1:0] mask_q,
    output logic [SRC_N-1:0] pend_q,
    output logic             irq_q
);
    logic [SRC_N-1:0] src_d;
    logic [SRC_N-1:0] mask_d;
    logic [SRC_N-1:0] pend_d;

    // Per-bit next state: a set beats a clear.
    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        assign src_d[i] = set_vec[i] | (src_q[i] & ~clr_vec[i]);
    end

    // Next mask value and the pending value derived from it.
    always_comb begin
        mask_d = mask_we ? mask_wd : mask_q;
        pend_d = src_d & ~mask_d;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            mask_q <= '0;
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            src_q  <= src_d;
            mask_q <= mask_d;
            pend_q <= pend_d;
            irq_q  <= |pend_d;
        end
    end
endmodule

// File: rtl/uirq_rd_mux.sv
// Module: uirq_rd_mux
// Read-data selector. It zero-extends the addressed register to the bus
// width. Unmapped offsets read as zero.
module uirq_rd_mux #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int SRC_N  = uirq_pkg::SRC_N
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SRC_N-1:0]  src_q,
    input  logic [SRC_N-1:0]  mask_q,
    input  logic [SRC_N-1:0]  pend_q,
    output logic [DATA_W-1:0] rd_data
);
    // Select the addressed register.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(uirq_pkg::OFF_PEND))
            rd_data[SRC_N-1:0] = pend_q;
        else if (rd_addr == ADDR_W'(uirq_pkg::OFF_SRC))
            rd_data[SRC_N-1:0] = src_q;
        else if (rd_addr == ADDR_W'(uirq_pkg::OFF_MASK))
            rd_data[SRC_N-1:0] = mask_q;
    end
endmodule

// File: rtl/uart_irq_combiner.sv
// Module: uart_irq_combiner (top)
// Merges the receive, error, transmit and modem causes into one level
// interrupt through source, mask and pending registers.
// Assumes single-cycle set pulses, writes that complete in one cycle, and a
// static chan_id.
module uart_irq_combiner #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int TRIG_W = 3,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              rx_set,
    input  logic              err_set,
    input  logic              tx_set,
    input  logic              modem_set,
    input  logic              fifo_on,
    input  logic [CNT_W-1:0]  tx_fill,
    input  logic [TRIG_W-1:0] tx_trig,
    input  logic [CHAN_W-1:0] chan_id,
    output logic              irq
);
    localparam int SRC_N = uirq_pkg::SRC_N;
    localparam int LVL_W = TRIG_W + uirq_pkg::SCALE_BITS;

    logic [LVL_W-1:0] lvl;
    logic             tx_regen;
    logic [SRC_N-1:0] set_vec;
    logic [SRC_N-1:0] clr_vec;
    logic             hit_pend, hit_src, hit_mask;
    logic [SRC_N-1:0] src_q, mask_q, pend_q;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wr_data[DATA_W-1:SRC_N];

    uirq_tx_level #(
        .TRIG_W(TRIG_W), .CHAN_W(CHAN_W), .CNT_W(CNT_W), .LVL_W(LVL_W)
    ) u_level (
        .tx_trig (tx_trig),
        .chan_id (chan_id),
        .tx_fill (tx_fill),
        .fifo_on (fifo_on),
        .level   (lvl),
        .tx_regen(tx_regen)
    );

    // Decode the write offset.
    always_comb begin
        hit_pend = reg_wr_en && (reg_wr_addr == ADDR_W'(uirq_pkg::OFF_PEND));
        hit_src  = reg_wr_en && (reg_wr_addr == ADDR_W'(uirq_pkg::OFF_SRC));
        hit_mask = reg_wr_en && (reg_wr_addr == ADDR_W'(uirq_pkg::OFF_MASK));
    end

    // Collect the set and clear vectors for the source register.
    always_comb begin
        set_vec = '0;
        set_vec[uirq_pkg::BIT_RX]  = rx_set;
        set_vec[uirq_pkg::BIT_ERR] = err_set;
        set_vec[uirq_pkg::BIT_TX]  = tx_set | tx_regen;
        set_vec[uirq_pkg::BIT_MDM] = modem_set;
        clr_vec = (hit_pend || hit_src) ? reg_wr_data[SRC_N-1:0] : '0;
    end

    uirq_src_bank #(.SRC_N(SRC_N)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .mask_we(hit_mask),
        .mask_wd(reg_wr_data[SRC_N-1:0]),
        .src_q  (src_q),
        .mask_q (mask_q),
        .pend_q (pend_q),
        .irq_q  (irq)
    );

    uirq_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_N(SRC_N)) u_rd (
        .rd_addr(reg_rd_addr),
        .src_q  (src_q),
        .mask_q (mask_q),
        .pend_q (pend_q),
        .rd_data(reg_rd_data)
    );
endmodule

// File: rtl/uirq_checker.sv
// Module: uirq_checker
// Property checker bound to uart_irq_combiner. It watches the ports and the
// register state and relates them across clock edges.
module uirq_checker #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int SRC_N  = uirq_pkg::SRC_N
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rx_set,
    input logic              err_set,
    input logic              tx_set,
    input logic              modem_set,
    input logic              fifo_on,
    input logic              tx_regen,
    input logic [SRC_N-1:0]  src_q,
    input logic [SRC_N-1:0]  mask_q,
    input logic [SRC_N-1:0]  pend_q,
    input logic              irq
);
    logic [SRC_N-1:0] pulses;
    assign pulses = {modem_set, tx_set, err_set, rx_set};

    AST_PEND_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q == (src_q & ~mask_q)); // R2

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend_q != '0)); // R3

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pulses != '0) |=> ((src_q & $past(pulses)) == $past(pulses))); // R8

    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(uirq_pkg::OFF_PEND) && pulses == '0 && !fifo_on)
        |=> ((src_q & $past(wr_data[SRC_N-1:0])) == '0)); // R4

    AST_TX_REGEN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_regen |=> src_q[uirq_pkg::BIT_TX]); // R6

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:SRC_N] == '0); // R9
endmodule

bind uart_irq_combiner uirq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_wr_addr),
    .wr_data  (reg_wr_data),
    .rd_data  (reg_rd_data),
    .rx_set   (rx_set),
    .err_set  (err_set),
    .tx_set   (tx_set),
    .modem_set(modem_set),
    .fifo_on  (fifo_on),
    .tx_regen (tx_regen),
    .src_q    (src_q),
    .mask_q   (mask_q),
    .pend_q   (pend_q),
    .irq      (irq)
);

// File: tb/uart_irq_combiner_test.sv
// Scoreboard bench. The driver task applies one cycle of stimulus and queues
// the expected register image. The monitor pops each item after the clock
// edge and reads all registers back through the read port.
module uart_irq_combiner_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rx_s = 0, er_s = 0, tx_s = 0, md_s = 0;
    logic        fon = 0;
    logic [7:0]  fill = '0;
    logic [2:0]  trig = '0;
    logic [2:0]  chan = 3'd1;
    logic        irq;

    always #5 clk = ~clk;

    uart_irq_combiner uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
        .reg_wr_data(wr_data), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
        .rx_set(rx_s), .err_set(er_s), .tx_set(tx_s), .modem_set(md_s),
        .fifo_on(fon), .tx_fill(fill), .tx_trig(trig), .chan_id(chan), .irq(irq)
    );

    typedef struct {
        logic [31:0] src;
        logic [31:0] msk;
        logic [31:0] pnd;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   fails  = 0;
    logic [3:0] m_src = '0;
    logic [3:0] m_msk = '0;
    bit   done = 0;

    // Threshold factor per port number, as given by R7.
    function automatic int scale_of(input int ch);
        case (ch)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction

    // Drive one cycle of stimulus and queue the expected result.
    task automatic step(input logic [3:0] set, input logic we, input logic [5:0] wa,
                        input logic [31:0] wd, input logic f_on, input logic [7:0] f_cnt,
                        input logic [2:0] tg, input logic [2:0] ch, input string tag);
        exp_t e;
        int   lvl;
        logic regen;
        logic [3:0] clr;
        @(negedge clk);
        {md_s, tx_s, er_s, rx_s} = set;
        wr_en = we; wr_addr = wa; wr_data = wd;
        fon = f_on; fill = f_cnt; trig = tg; chan = ch;
        lvl   = int'(tg) * scale_of(int'(ch));
        regen = f_on && (int'(f_cnt) <= lvl);
        clr   = (we && (wa == 6'h30 || wa == 6'h34)) ? wd[3:0] : 4'h0;
        m_src = (m_src & ~clr) | set | {1'b0, regen, 2'b00};
        if (we && wa == 6'h38) m_msk = wd[3:0];
        e.src = {28'h0, m_src};
        e.msk = {28'h0, m_msk};
        e.pnd = {28'h0, m_src & ~m_msk};
        e.irq = |(m_src & ~m_msk);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: after each edge, read back every register and compare with the oldest queued item.
    initial begin
        logic [31:0] a_src, a_msk, a_pnd, a_oth;
        logic        a_irq;
        exp_t        e;
        wait (rst_n);
        forever begin
            @(posedge clk);
            #1 rd_addr = 6'h34;
            #1 a_src = rd_data; rd_addr = 6'h38;
            #1 a_msk = rd_data; rd_addr = 6'h30;
            #1 a_pnd = rd_data; rd_addr = 6'h3C;
            #1 a_oth = rd_data; a_irq = irq;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                checks++;
                if (a_src !== e.src || a_msk !== e.msk || a_pnd !== e.pnd ||
                    a_irq !== e.irq || a_oth !== 32'h0) begin
                    fails++;
                    $display("FAIL %s: src=%h/%h mask=%h/%h pend=%h/%h irq=%b/%b other=%h/0 (actual/expected)",
                             e.tag, a_src, e.src, a_msk, e.msk, a_pnd, e.pnd, a_irq, e.irq, a_oth);
                end
            end
        end
    end

    // Watchdog: counts a hang as a failed check.
    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state is all zero
        rd_addr = 6'h30; #1;
        checks++;
        if (rd_data !== 32'h0 || irq !== 1'b0) begin
            fails++; $display("FAIL R9 reset pend: actual=%h irq=%b expected=0", rd_data, irq);
        end
        rd_addr = 6'h34; #1;
        checks++;
        if (rd_data !== 32'h0) begin
            fails++; $display("FAIL R9 reset src: actual=%h expected=0", rd_data);
        end
        rd_addr = 6'h38; #1;
        checks++;
        if (rd_data !== 32'h0) begin
            fails++; $display("FAIL R9 reset mask: actual=%h expected=0", rd_data);
        end
        rst_n = 1'b1;

        step(4'h0, 0, 6'h00, 32'h0, 0, 8'd0, 3'd0, 3'd1, "R9 idle after reset");
        step(4'h1, 0, 6'h00, 32'h0, 0, 8'd0, 3'd0, 3'd1, "R1 rx pulse bit0 / R3 irq");
        step(4'h0, 1, 6'h38, 32'hFFFF_FFF1, 0, 8'd0, 3'd0, 3'd1, "R2 mask rx / R9 upper bits");
        step(4'h2, 0, 6'h00, 32'h0, 0, 8'd0, 3'd0, 3'd1, "R1 err pulse bit1 / R3");
        step(4'h0, 1, 6'h30, 32'h2, 0, 8'd0, 3'd0, 3'd1, "R4 pending clear also clears source");
        step(4'h8, 0, 6'h00, 32'h0, 0, 8'd0, 3'd0, 3'd1, "R1 modem pulse bit3");
        step(4'h0, 1, 6'h34, 32'h8, 0, 8'd0, 3'd0, 3'd1, "R5 source clear");
        step(4'h1, 1, 6'h34, 32'h1, 0, 8'd0, 3'd0, 3'd1, "R8 set beats clear");
        step(4'h0, 1, 6'h10, 32'hF, 0, 8'd0, 3'd0, 3'd1, "R10 write to other offset ignored");
        step(4'h0, 1, 6'h3C, 32'hF, 0, 8'd0, 3'd0, 3'd1, "R10 write to 0x3C ignored");
        step(4'h0, 1, 6'h38, 32'h0, 0, 8'd0, 3'd0, 3'd1, "R2 unmask shows pending");
        step(4'h0, 1, 6'h30, 32'h1, 0, 8'd0, 3'd0, 3'd1, "R4 pending clear / R3 irq low");
        step(4'h4, 0, 6'h00, 32'h0, 0, 8'd0, 3'd0, 3'd1, "R1 tx pulse bit2");
        step(4'h0, 1, 6'h34, 32'h4, 0, 8'd0, 3'd0, 3'd1, "R5 tx source clear");
        step(4'h0, 0, 6'h00, 32'h0, 0, 8'd0, 3'd7, 3'd0, "R6 fifo off no regen");
        step(4'h0, 0, 6'h00, 32'h0, 1, 8'd16, 3'd2, 3'd1, "R6 R7 port1 fill equals level");
        step(4'h0, 1, 6'h34, 32'h4, 1, 8'd16, 3'd2, 3'd1, "R8 regen beats clear");
        step(4'h0, 1, 6'h34, 32'h4, 1, 8'd17, 3'd2, 3'd1, "R6 port1 fill above level");
        step(4'h0, 0, 6'h00, 32'h0, 1, 8'd32, 3'd1, 3'd0, "R7 port0 x32 at level");
        step(4'h0, 1, 6'h30, 32'h4, 1, 8'd33, 3'd1, 3'd0, "R7 port0 above level");
        step(4'h0, 0, 6'h00, 32'h0, 1, 8'd6, 3'd3, 3'd2, "R7 port2 x2 at level");
        step(4'h0, 1, 6'h34, 32'h4, 1, 8'd7, 3'd3, 3'd2, "R7 port2 above level");
        step(4'h0, 0, 6'h00, 32'h0, 1, 8'd7, 3'd3, 3'd3, "R7 port3 above level");
        step(4'h0, 0, 6'h00, 32'h0, 1, 8'd6, 3'd3, 3'd3, "R7 port3 at level");
        step(4'h0, 1, 6'h34, 32'h4, 1, 8'd9, 3'd1, 3'd4, "R7 port4 above level");
        step(4'h0, 0, 6'h00, 32'h0, 1, 8'd8, 3'd1, 3'd4, "R7 port4 at level");
        step(4'h0, 1, 6'h34, 32'h4, 1, 8'd1, 3'd7, 3'd5, "R7 port5 level zero fill1");
        step(4'h0, 0, 6'h00, 32'h0, 1, 8'd0, 3'd7, 3'd5, "R7 port5 level zero fill0");
        step(4'h0, 1, 6'h38, 32'h4, 1, 8'd1, 3'd7, 3'd5, "R2 mask tx");
        step(4'h0, 1, 6'h30, 32'h4, 0, 8'd0, 3'd0, 3'd1, "R4 clear while masked");
        step(4'hB, 0, 6'h00, 32'h0, 0, 8'd0, 3'd0, 3'd1, "R1 several pulses");
        step(4'h0, 1, 6'h30, 32'hF, 0, 8'd0, 3'd0, 3'd1, "R4 clear all");
        step(4'h0, 0, 6'h00, 32'h0, 0, 8'd0, 3'd0, 3'd1, "R3 idle");

        wait (sb_q.size() == 0);
        @(posedge clk); #6;
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule